// File: doc/BRIEF.md
# Power-Well Sequencing Glue

This block turns a handful of motherboard power inputs into the signals that sequence the power wells. The inputs are the power-supply good level, the S3 and S5 sleep levels, CPU presence, the front-panel reset and two LED blink requests. The outputs are one push-pull power-good level and a set of open-drain drives. Each open-drain output is modelled as a pull-low enable: 1 drives the pin low, and 0 releases it to high impedance. All inputs are asynchronous to the block clock, so each one passes through a synchroniser of `SYNC_STAGES` flops (two by default) before any logic uses it.

The internal backfeed level is the released state of the backfeed-cut drive. A small state machine watches this level together with S5 and keeps a latched backfeed flag for suspend-to-RAM.

The flag machine has five states:
- `ST_PWRUP`: entered on reset. It waits for the backfeed level to go low once.
- `ST_IDLE`: backfeed is low and the machine is armed.
- `ST_LATCHED`: the flag is high.
- `ST_SUSPEND`: S5 has dropped while the flag was set.
- `ST_RAISED`: backfeed rose while S5 was low.

The machine has these transitions:
- PWRUP→IDLE when backfeed is low.
- IDLE→LATCHED when backfeed is high and S5 is high.
- IDLE→RAISED when backfeed is high and S5 is low.
- LATCHED→IDLE when backfeed is low.
- LATCHED→SUSPEND when S5 is low.
- SUSPEND→IDLE when backfeed is low.
- RAISED→IDLE when backfeed is low.

The flag is high only in `ST_LATCHED`.

Top module: `pwr_seq_glue`

## Requirements
- R1: `bfcut_pull_o` is 1 exactly when the synchronised power-good and S3 inputs are both 1; otherwise it is 0 (released).
- R2: `psu_on_pull_o` is 1 exactly when the synchronised CPU-present input is 0 and S3 is 1.
- R3: `pwrgd_3v_o` is the AND of the synchronised front-panel reset and power-good inputs.
- R4: `sclk_gate_pull_o` is 1 when the 3.3 V power-good is 1, and 0 when it is 0.
- R5: Each LED pull (`led_yel_pull_o` for `blink_yel_i`, `led_grn_pull_o` for `blink_grn_i`) is 0 only when its blink input and S5 are both 1; otherwise it is 1.
- R6: After reset the latched flag stays 0 while backfeed is high, whatever S5 does, until backfeed has been low at least once.
- R7: The flag goes to 1 when backfeed rises while S5 is 1. A rise while S5 is 0 does not set it, and neither does a later rise of S5 while backfeed stays high.
- R8: The flag clears when S5 falls. It stays 0 while S5 is low and after S5 returns high, up to the next armed backfeed rise.
- R9: The flag clears when backfeed returns low, and the machine re-arms.
- R10: While `rst_n` is low, all synchroniser flops and the flag machine are cleared. The outputs are then: flag 0, `bfcut_pull_o` 0, `psu_on_pull_o` 0, `pwrgd_3v_o` 0, `sclk_gate_pull_o` 0, and both LED pulls 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psu_good_i | input | 1 | Power-supply good level |
| slp3_i | input | 1 | S3 sleep level (1 = awake) |
| slp5_i | input | 1 | S5 sleep level (1 = awake) |
| cpu_sense_i | input | 1 | CPU presence sense (0 enables supply turn-on) |
| fp_reset_i | input | 1 | Front-panel reset level |
| blink_yel_i | input | 1 | Yellow LED blink request |
| blink_grn_i | input | 1 | Green LED blink request |
| bfcut_pull_o | output | 1 | Backfeed-cut pull-low enable |
| bf_latched_o | output | 1 | Latched backfeed flag |
| psu_on_pull_o | output | 1 | Supply turn-on pull-low enable |
| pwrgd_3v_o | output | 1 | 3.3 V power-good |
| sclk_gate_pull_o | output | 1 | Suspend clock gate pull-low enable |
| led_yel_pull_o | output | 1 | Yellow LED pull-low enable |
| led_grn_pull_o | output | 1 | Green LED pull-low enable |

## Verification
On every cycle, the assertions inside the flag machine check three things:
- the flag never rises unless S5 was high and the machine was armed;
- every clear of the flag follows an S5 drop or a backfeed return;
- a pulled backfeed-cut is followed by a low flag.

Only the bench's scenarios can show the whole-sequence behaviour: the silent power-up, suspend sequence one with S5 held high, and sequence two with the S5 drop and return. The bench also covers a backfeed rise seen while S5 was low, and the truth tables of the combinational open-drain outputs under varied input sets.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Bit positions inside the synchroniser bus
    localparam int IDX_PSU   = 0;
    localparam int IDX_S3    = 1;
    localparam int IDX_S5    = 2;
    localparam int IDX_CPU   = 3;
    localparam int IDX_FP    = 4;
    localparam int IDX_BYEL  = 5;
    localparam int IDX_BGRN  = 6;
    localparam int NUM_ASYNC = 7;

    typedef enum logic [2:0] {
        ST_PWRUP   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_LATCHED = 3'd2,
        ST_SUSPEND = 3'd3,
        ST_RAISED  = 3'd4
    } bf_state_e;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/pwr_glue.sv
module pwr_glue (
    input  logic psu_good,
    input  logic slp3,
    input  logic slp5,
    input  logic cpu_sense,
    input  logic fp_reset,
    input  logic blink_yel,
    input  logic blink_grn,
    output logic bfcut_pull,
    output logic bf_high,
    output logic psu_on_pull,
    output logic pwrgd_3v,
    output logic sclk_gate_pull,
    output logic led_yel_pull,
    output logic led_grn_pull
);
    always_comb begin
        bfcut_pull     = psu_good & slp3;
        bf_high        = ~bfcut_pull;
        psu_on_pull    = ~cpu_sense & slp3;
        pwrgd_3v       = fp_reset & psu_good;
        sclk_gate_pull = pwrgd_3v;
        led_yel_pull   = ~(blink_yel & slp5);
        led_grn_pull   = ~(blink_grn & slp5);
    end
endmodule

// File: rtl/pwr_bf_latch.sv
module pwr_bf_latch
    import pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bf_high,
    input  logic slp5,
    output logic flag_o
);
    bf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:   if (!bf_high) state_d = ST_IDLE;
            ST_IDLE:    if (bf_high)  state_d = slp5 ? ST_LATCHED : ST_RAISED;
            ST_LATCHED: begin
                if (!bf_high)   state_d = ST_IDLE;
                else if (!slp5) state_d = ST_SUSPEND;
            end
            ST_SUSPEND: if (!bf_high) state_d = ST_IDLE;
            ST_RAISED:  if (!bf_high) state_d = ST_IDLE;
            default:    state_d = ST_PWRUP;
        endcase
    end

    always_comb begin
        flag_o = (state_q == ST_LATCHED);
    end

    AST_SET_NEEDS_S5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(slp5) && $past(bf_high)); // R7
    AST_SET_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(state_q) == ST_IDLE); // R6
    AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> (!$past(slp5) || !$past(bf_high))); // R8
    AST_CUT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !bf_high |=> !flag_o); // R9
endmodule

// File: rtl/pwr_seq_glue.sv
module pwr_seq_glue
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psu_good_i,
    input  logic slp3_i,
    input  logic slp5_i,
    input  logic cpu_sense_i,
    input  logic fp_reset_i,
    input  logic blink_yel_i,
    input  logic blink_grn_i,
    output logic bfcut_pull_o,
    output logic bf_latched_o,
    output logic psu_on_pull_o,
    output logic pwrgd_3v_o,
    output logic sclk_gate_pull_o,
    output logic led_yel_pull_o,
    output logic led_grn_pull_o
);
    logic [NUM_ASYNC-1:0] raw_bus;
    logic [NUM_ASYNC-1:0] syn_bus;
    logic                 bf_high;

    always_comb begin
        raw_bus           = '0;
        raw_bus[IDX_PSU]  = psu_good_i;
        raw_bus[IDX_S3]   = slp3_i;
        raw_bus[IDX_S5]   = slp5_i;
        raw_bus[IDX_CPU]  = cpu_sense_i;
        raw_bus[IDX_FP]   = fp_reset_i;
        raw_bus[IDX_BYEL] = blink_yel_i;
        raw_bus[IDX_BGRN] = blink_grn_i;
    end

    pwr_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (syn_bus)
    );

    pwr_glue u_glue (
        .psu_good       (syn_bus[IDX_PSU]),
        .slp3           (syn_bus[IDX_S3]),
        .slp5           (syn_bus[IDX_S5]),
        .cpu_sense      (syn_bus[IDX_CPU]),
        .fp_reset       (syn_bus[IDX_FP]),
        .blink_yel      (syn_bus[IDX_BYEL]),
        .blink_grn      (syn_bus[IDX_BGRN]),
        .bfcut_pull     (bfcut_pull_o),
        .bf_high        (bf_high),
        .psu_on_pull    (psu_on_pull_o),
        .pwrgd_3v       (pwrgd_3v_o),
        .sclk_gate_pull (sclk_gate_pull_o),
        .led_yel_pull   (led_yel_pull_o),
        .led_grn_pull   (led_grn_pull_o)
    );

    pwr_bf_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .bf_high (bf_high),
        .slp5    (syn_bus[IDX_S5]),
        .flag_o  (bf_latched_o)
    );

    AST_PG_GATES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_gate_pull_o |-> pwrgd_3v_o); // R4
endmodule

// File: tb/pwr_seq_glue_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_glue_tb_top;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 0, s3 = 0, s5 = 0, cpu = 0, fp = 0, by = 0, bg = 0;
    logic bfcut, lat, psuon, pwrgd, sclk, ledy, ledg;

    int n_cmp = 0;
    int n_bad = 0;
    item_t sb_q[$];
    event  pushed;

    always #10 clk = ~clk;

    pwr_seq_glue dut_i (
        .clk(clk), .rst_n(rst_n),
        .psu_good_i(pg), .slp3_i(s3), .slp5_i(s5), .cpu_sense_i(cpu),
        .fp_reset_i(fp), .blink_yel_i(by), .blink_grn_i(bg),
        .bfcut_pull_o(bfcut), .bf_latched_o(lat), .psu_on_pull_o(psuon),
        .pwrgd_3v_o(pwrgd), .sclk_gate_pull_o(sclk),
        .led_yel_pull_o(ledy), .led_grn_pull_o(ledg)
    );

    // Expected vector order: {bfcut, latched, psu_on, pwrgd, sclk, led_yel, led_grn}
    task automatic step(input logic a_pg, input logic a_s3, input logic a_s5,
                        input logic a_cpu, input logic a_fp, input logic a_by,
                        input logic a_bg, input logic [6:0] e, input string tag);
        item_t it;
        @(negedge clk);
        pg = a_pg; s3 = a_s3; s5 = a_s5; cpu = a_cpu; fp = a_fp; by = a_by; bg = a_bg;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        ->pushed;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: compares after the synchroniser and state machine have settled
    initial begin
        forever begin
            @(pushed);
            repeat (4) @(negedge clk);
            begin
                item_t it;
                logic [6:0] act;
                it  = sb_q.pop_front();
                act = {bfcut, lat, psuon, pwrgd, sclk, ledy, ledg};
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, checked while reset is held
        n_cmp++;
        if ({bfcut, lat, psuon, pwrgd, sclk, ledy, ledg} !== 7'b0000011) begin
            n_bad++;
            $display("FAIL R10: actual %b expected %b",
                     {bfcut, lat, psuon, pwrgd, sclk, ledy, ledg}, 7'b0000011);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,0,0,0, 7'b0000011, "R10 after release");
        // Power-up: backfeed high, S5 rises, flag must stay low
        step(0,0,1,1,1,1,1, 7'b0000000, "R6 S5 up during power-up");
        step(1,0,1,1,1,1,1, 7'b0001100, "R3 R4 power good");
        step(1,1,1,1,1,1,1, 7'b1001100, "R1 R6 backfeed cut, no flag");
        step(1,1,1,0,1,1,1, 7'b1011100, "R2 supply on");
        step(1,1,1,1,1,1,1, 7'b1001100, "R2 supply off");
        // Sequence one: S5 stays high
        step(1,0,1,1,1,1,1, 7'b0101100, "R7 seq1 set");
        step(1,1,1,1,1,1,1, 7'b1001100, "R9 seq1 clear");
        // Sequence two: S5 drops and returns
        step(1,0,1,1,1,1,1, 7'b0101100, "R7 seq2 set");
        step(1,0,0,1,1,1,1, 7'b0001111, "R8 R5 seq2 S5 drop");
        step(1,0,1,1,1,1,1, 7'b0001100, "R8 seq2 S5 back");
        step(1,1,1,1,1,1,1, 7'b1001100, "R9 seq2 end");
        // Rise while S5 low must not set, nor the later S5 rise
        step(1,1,0,1,1,1,1, 7'b1001111, "R5 S5 low");
        step(1,0,0,1,1,1,1, 7'b0001111, "R7 rise with S5 low");
        step(1,0,1,1,1,1,1, 7'b0001100, "R7 S5 rise after");
        step(1,1,1,1,1,1,1, 7'b1001100, "R9 re-arm");
        // Rise via power-good drop
        step(0,1,1,1,1,1,1, 7'b0100000, "R7 R1 psu drop set");
        step(0,1,1,1,0,1,1, 7'b0100000, "R3 fp low");
        step(1,1,1,1,0,0,1, 7'b1000010, "R3 R5 R9 yel only");
        step(1,1,1,1,1,1,0, 7'b1001101, "R5 grn only");
        step(1,1,1,0,1,1,1, 7'b1011100, "R2 R4 final");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule